// File: doc/BRIEF.md
# Hit Time Clustering Array

This block collects hit times that arrive during a frame and groups the ones that lie close together into clusters. It is built as a chain of identical cells. A hit time enters the first cell. An empty cell takes the hit as the seed of a new cluster. An occupied cell absorbs the hit when it falls inside a programmable window around that cell's seed. Any other hit moves on to the next cell one clock later. The window is asymmetric: one limit sets how far below the seed a hit may lie, and a separate limit sets how far above. Because each hit advances one cell per cycle, the array takes a new hit on every clock.

When the frame ends, the block stops taking hits and waits until every hit still moving through the chain has settled. The same chain then works as a shift register. It presents one cluster per cycle as a triple: seed time, hit count and sum of the hit times. A downstream divider can form the cluster average from the count and the sum. After the drain, the chain is empty and ready for the next frame. A hit that passes the last cell without finding a home is dropped and sets a sticky error flag.

Top module: `hcl_array`

## Requirements
- R1: An accepted hit that reaches an empty cell makes that cell a cluster with seed equal to the hit time, count 1 and sum equal to the hit time.
- R2: A hit t matches an occupied cell with seed s when s - lim_lo <= t <= s + lim_hi, both bounds included. A matching hit is absorbed: the sum grows by t, the count grows by 1, and the seed does not change.
- R3: A hit that matches no occupied cell goes on down the chain. Clusters are drained in the order in which their seeds arrived.
- R4: A cell holds at most MAX_HITS hits. A matching hit that arrives at a full cell goes on to the next cell, where it can start a new cluster.
- R5: A hit that passes the last cell unmatched adds nothing to any cluster and sets hit_lost. hit_lost stays high until reset.
- R6: When eof is high while hit_rdy is high, the frame ends. A hit that is accepted in that same cycle belongs to the frame. hit_rdy is low for the 2*N_CELLS+1 cycles after that edge.
- R7: Counting the eof edge as cycle 0, cluster j (counting from 0) appears on clu_time/clu_num/clu_sum with clu_vld high in cycle N_CELLS+j. clu_vld is low in every other cycle.
- R8: drain_done is high for exactly one cycle, in cycle 2*N_CELLS. Every cell is empty afterwards, so the next frame starts with no clusters.
- R9: hit_vld and eof have no effect while hit_rdy is low.
- R10: After reset, hit_rdy is 1 and clu_vld, drain_done and hit_lost are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_vld | input | 1 | Hit time strobe |
| hit_time | input | TIME_W | Hit time, unsigned |
| hit_rdy | output | 1 | Array accepts hits and eof |
| eof | input | 1 | End-of-frame strobe |
| lim_lo | input | LIM_W | Window extent below the seed |
| lim_hi | input | LIM_W | Window extent above the seed |
| clu_vld | output | 1 | Cluster triple valid |
| clu_time | output | TIME_W | Cluster seed time |
| clu_num | output | NUM_W | Hits in the cluster |
| clu_sum | output | SUM_W | Sum of the cluster's hit times |
| drain_done | output | 1 | One-cycle pulse when the drain finishes |
| hit_lost | output | 1 | Sticky flag: a hit fell off the chain |

## Verification
The bench runs several kinds of frame. It sends hits placed exactly on both window edges and one step outside them, so an off-by-one in either limit, or a swap of the two limits, gives the wrong clusters. It sends back-to-back repeats of one time, which exercise the per-cell cap, and more distinct times than there are cells, which show whether overflow sets the flag and drops the hit. It also sends a hit in the same cycle as eof, a frame with no hits, and hits offered during a drain. Together these show whether acceptance, the settle and drain timing, and the clearing of the chain between frames behave as the requirements state.

// File: rtl/hcl_pkg.sv
package hcl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_SHIFT  = 2'd2,
      ST_DONE   = 2'd3
   } hcl_state_e;
endpackage

// File: rtl/hcl_cell.sv
module hcl_cell #(
   parameter int TIME_W   = 16,
   parameter int LIM_W    = 8,
   parameter int MAX_HITS = 32,
   localparam int NUM_W   = $clog2(MAX_HITS + 1),
   localparam int SUM_W   = TIME_W + NUM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              in_vld,
   input  logic [TIME_W-1:0] in_time,
   input  logic [LIM_W-1:0]  lim_lo,
   input  logic [LIM_W-1:0]  lim_hi,
   input  logic              nb_occ,
   input  logic [TIME_W-1:0] nb_seed,
   input  logic [NUM_W-1:0]  nb_num,
   input  logic [SUM_W-1:0]  nb_sum,
   output logic              pass_vld,
   output logic [TIME_W-1:0] pass_time,
   output logic              occ,
   output logic [TIME_W-1:0] seed,
   output logic [NUM_W-1:0]  num,
   output logic [SUM_W-1:0]  sum
);
   localparam int DW = TIME_W + 2;

   logic signed [DW-1:0] diff, lo_b, hi_b;
   logic                 in_win, has_room;

   always_comb begin
      diff     = $signed({2'b00, in_time}) - $signed({2'b00, seed});
      lo_b     = -$signed({{(DW-LIM_W){1'b0}}, lim_lo});
      hi_b     = $signed({{(DW-LIM_W){1'b0}}, lim_hi});
      in_win   = (diff >= lo_b) && (diff <= hi_b);
      has_room = num < NUM_W'(MAX_HITS);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ       <= 1'b0;
         seed      <= '0;
         num       <= '0;
         sum       <= '0;
         pass_vld  <= 1'b0;
         pass_time <= '0;
      end else if (shift_en) begin
         occ      <= nb_occ;
         seed     <= nb_seed;
         num      <= nb_num;
         sum      <= nb_sum;
         pass_vld <= 1'b0;
      end else begin
         pass_vld <= 1'b0;
         if (in_vld) begin
            if (!occ) begin
               occ  <= 1'b1;
               seed <= in_time;
               num  <= NUM_W'(1);
               sum  <= SUM_W'(in_time);
            end else if (in_win && has_room) begin
               num <= num + NUM_W'(1);
               sum <= sum + SUM_W'(in_time);
            end else begin
               pass_vld  <= 1'b1;
               pass_time <= in_time;
            end
         end
      end
   end

   AST_NUM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      occ |-> (num >= NUM_W'(1) && num <= NUM_W'(MAX_HITS))); // R4
   AST_EMPTY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      !occ |-> (num == '0)); // R8
   AST_SEED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (occ && !shift_en) |=> (occ && $stable(seed))); // R2
   AST_NUM_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (occ && !shift_en) |=> (num >= $past(num))); // R2
   AST_SUM_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (occ && !shift_en) |=> (sum >= $past(sum))); // R2
endmodule

// File: rtl/hcl_ctrl.sv
module hcl_ctrl #(
   parameter int N_CELLS = 32,
   localparam int CNT_W  = $clog2(N_CELLS) + 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic eof,
   output logic rdy,
   output logic shift_en,
   output logic done
);
   import hcl_pkg::*;

   hcl_state_e st;
   logic [CNT_W-1:0] cnt;
   logic last;

   assign last     = (cnt == CNT_W'(N_CELLS - 1));
   assign rdy      = (st == ST_IDLE);
   assign shift_en = (st == ST_SHIFT);
   assign done     = (st == ST_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               cnt <= '0;
               if (eof) st <= ST_SETTLE;
            end
            ST_SETTLE: begin
               cnt <= last ? '0 : cnt + CNT_W'(1);
               if (last) st <= ST_SHIFT;
            end
            ST_SHIFT: begin
               cnt <= last ? '0 : cnt + CNT_W'(1);
               if (last) st <= ST_DONE;
            end
            default: begin
               cnt <= '0;
               st  <= ST_IDLE;
            end
         endcase
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && rdy)); // R8
   AST_EOF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && eof) |=> !rdy); // R6
   AST_SHIFT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(shift_en)) |=> shift_en); // R7
endmodule

// File: rtl/hcl_array.sv
module hcl_array #(
   parameter int N_CELLS  = 32,
   parameter int TIME_W   = 16,
   parameter int LIM_W    = 8,
   parameter int MAX_HITS = 32,
   localparam int NUM_W   = $clog2(MAX_HITS + 1),
   localparam int SUM_W   = TIME_W + NUM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_vld,
   input  logic [TIME_W-1:0] hit_time,
   output logic              hit_rdy,
   input  logic              eof,
   input  logic [LIM_W-1:0]  lim_lo,
   input  logic [LIM_W-1:0]  lim_hi,
   output logic              clu_vld,
   output logic [TIME_W-1:0] clu_time,
   output logic [NUM_W-1:0]  clu_num,
   output logic [SUM_W-1:0]  clu_sum,
   output logic              drain_done,
   output logic              hit_lost
);
   generate
      if (N_CELLS < 2) begin : g_bad_cells
         $error("hcl_array: N_CELLS must be at least 2");
      end
      if (MAX_HITS < 1) begin : g_bad_hits
         $error("hcl_array: MAX_HITS must be at least 1");
      end
      if (LIM_W >= TIME_W) begin : g_bad_lim
         $error("hcl_array: LIM_W must be below TIME_W");
      end
   endgenerate

   logic shift_en, rdy;

   logic              lk_vld  [N_CELLS];
   logic [TIME_W-1:0] lk_time [N_CELLS];
   logic              c_occ   [N_CELLS];
   logic [TIME_W-1:0] c_seed  [N_CELLS];
   logic [NUM_W-1:0]  c_num   [N_CELLS];
   logic [SUM_W-1:0]  c_sum   [N_CELLS];

   hcl_ctrl #(.N_CELLS(N_CELLS)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .eof      (eof),
      .rdy      (rdy),
      .shift_en (shift_en),
      .done     (drain_done)
   );

   assign hit_rdy = rdy;

   genvar gi;
   generate
      for (gi = 0; gi < N_CELLS; gi++) begin : g_cell
         logic              in_v;
         logic [TIME_W-1:0] in_t;
         logic              nb_o;
         logic [TIME_W-1:0] nb_t;
         logic [NUM_W-1:0]  nb_n;
         logic [SUM_W-1:0]  nb_s;

         if (gi == 0) begin : g_head
            assign in_v = hit_vld && rdy;
            assign in_t = hit_time;
         end else begin : g_body
            assign in_v = lk_vld[gi-1];
            assign in_t = lk_time[gi-1];
         end

         if (gi == N_CELLS - 1) begin : g_tail
            assign nb_o = 1'b0;
            assign nb_t = '0;
            assign nb_n = '0;
            assign nb_s = '0;
         end else begin : g_link
            assign nb_o = c_occ[gi+1];
            assign nb_t = c_seed[gi+1];
            assign nb_n = c_num[gi+1];
            assign nb_s = c_sum[gi+1];
         end

         hcl_cell #(
            .TIME_W   (TIME_W),
            .LIM_W    (LIM_W),
            .MAX_HITS (MAX_HITS)
         ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .shift_en  (shift_en),
            .in_vld    (in_v),
            .in_time   (in_t),
            .lim_lo    (lim_lo),
            .lim_hi    (lim_hi),
            .nb_occ    (nb_o),
            .nb_seed   (nb_t),
            .nb_num    (nb_n),
            .nb_sum    (nb_s),
            .pass_vld  (lk_vld[gi]),
            .pass_time (lk_time[gi]),
            .occ       (c_occ[gi]),
            .seed      (c_seed[gi]),
            .num       (c_num[gi]),
            .sum       (c_sum[gi])
         );
      end
   endgenerate

   assign clu_vld  = shift_en && c_occ[0];
   assign clu_time = c_seed[0];
   assign clu_num  = c_num[0];
   assign clu_sum  = c_sum[0];

   always_ff @(posedge clk) begin
      if (!rst_n)                 hit_lost <= 1'b0;
      else if (lk_vld[N_CELLS-1]) hit_lost <= 1'b1;
   end

   AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      hit_lost |=> hit_lost); // R5
   AST_VLD_ONLY_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      clu_vld |-> !hit_rdy); // R7
   AST_NO_PASS_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |-> !lk_vld[N_CELLS-1]); // R6
   AST_OUT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      clu_vld |-> (clu_num != '0)); // R1
endmodule

// File: tb/hcl_array_bench.sv
module hcl_array_bench;
   localparam int N   = 8;
   localparam int TW  = 16;
   localparam int LW  = 8;
   localparam int MH  = 4;
   localparam int NW  = $clog2(MH + 1);
   localparam int SW  = TW + NW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hit_vld = 1'b0;
   logic [TW-1:0] hit_time = '0;
   logic eof = 1'b0;
   logic [LW-1:0] lim_lo = '0, lim_hi = '0;
   logic hit_rdy, clu_vld, drain_done, hit_lost;
   logic [TW-1:0] clu_time;
   logic [NW-1:0] clu_num;
   logic [SW-1:0] clu_sum;

   int total = 0, bad = 0, cyc = 0;

   // reference model: cluster list, frame phase counter, lost flag
   int m_seed[$], m_num[$], m_sum[$];
   int k = -1;
   bit m_lost = 0;

   always #10 clk = ~clk;

   hcl_array #(.N_CELLS(N), .TIME_W(TW), .LIM_W(LW), .MAX_HITS(MH)) u_hcl_array (
      .clk(clk), .rst_n(rst_n), .hit_vld(hit_vld), .hit_time(hit_time),
      .hit_rdy(hit_rdy), .eof(eof), .lim_lo(lim_lo), .lim_hi(lim_hi),
      .clu_vld(clu_vld), .clu_time(clu_time), .clu_num(clu_num),
      .clu_sum(clu_sum), .drain_done(drain_done), .hit_lost(hit_lost));

   task automatic chk(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d cycle=%0d", req, act, exp, cyc);
      end
   endtask

   function automatic void model_hit(input int t);
      for (int i = 0; i < m_seed.size(); i++) begin
         if (t >= m_seed[i] - int'(lim_lo) && t <= m_seed[i] + int'(lim_hi)
             && m_num[i] < MH) begin
            m_num[i]++; m_sum[i] += t;
            return;
         end
      end
      if (m_seed.size() < N) begin
         m_seed.push_back(t); m_num.push_back(1); m_sum.push_back(t);
      end else m_lost = 1;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         k = -1; m_lost = 0;
         m_seed.delete(); m_num.delete(); m_sum.delete();
      end else begin
         bit idle;
         idle = (k < 0);
         if (k >= 0) begin
            k++;
            if (k == 2*N + 1) begin
               k = -1;
               m_seed.delete(); m_num.delete(); m_sum.delete();
            end
         end
         // R9: inputs count only when the model says ready
         if (idle && hit_vld) model_hit(int'(hit_time));
         if (idle && eof) k = 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         bit ev;
         int j;
         ev = 0; j = k - N;
         chk("R6 hit_rdy", hit_rdy, k < 0);
         if (k >= N && k < 2*N && j < m_seed.size()) ev = 1;
         chk("R7 clu_vld", clu_vld, ev);
         if (ev && clu_vld) begin
            chk("R1/R2/R3 clu_time", clu_time, m_seed[j]);
            chk("R2/R4 clu_num", clu_num, m_num[j]);
            chk("R2/R4 clu_sum", clu_sum, m_sum[j]);
         end
         chk("R8 drain_done", drain_done, k == 2*N);
         if (k == 2*N) chk("R5 hit_lost", hit_lost, m_lost);
      end
   end

   task automatic send(input int t);
      hit_vld = 1'b1; hit_time = TW'(t);
      @(negedge clk);
      hit_vld = 1'b0;
   endtask

   task automatic end_frame(input int t_with_eof);
      eof = 1'b1;
      if (t_with_eof >= 0) begin hit_vld = 1'b1; hit_time = TW'(t_with_eof); end
      @(negedge clk);
      eof = 1'b0; hit_vld = 1'b0;
      repeat (2*N + 3) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 hit_rdy", hit_rdy, 1);
      chk("R10 clu_vld", clu_vld, 0);
      chk("R10 drain_done", drain_done, 0);
      chk("R10 hit_lost", hit_lost, 0);

      // R1 R2 R3: window edges, lo=5 hi=10
      lim_lo = 8'd5; lim_hi = 8'd10;
      send(100); send(110); send(111); send(95); send(94); send(121);
      @(negedge clk); send(122); send(89);
      end_frame(-1);

      // asymmetric swap plus hits offered during drain (R9)
      lim_lo = 8'd10; lim_hi = 8'd2;
      send(500); send(490); send(489); send(502); send(503);
      eof = 1'b1; @(negedge clk); eof = 1'b0;
      send(500); send(700); eof = 1'b1; @(negedge clk); eof = 1'b0;
      repeat (2*N + 3) @(negedge clk);

      // R4 cap per cell
      lim_lo = 8'd3; lim_hi = 8'd3;
      repeat (6) send(200);
      send(202); send(204);
      end_frame(-1);

      // empty frame, then hit in the eof cycle (R6)
      end_frame(-1);
      send(1000);
      end_frame(1001);

      // R8 chain is empty for the next frame
      send(3000);
      end_frame(-1);

      // R5 overflow: more distinct times than cells
      lim_lo = 8'd1; lim_hi = 8'd1;
      for (int i = 0; i < N + 2; i++) send(4000 + 50*i);
      end_frame(-1);
      chk("R5 hit_lost sticky", hit_lost, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule